// File: doc/BRIEF.md
# Exception Entry and Return Sequencer

This block steers a small 32-bit RISC core into and out of exception handlers. It recognises three classes of events. The first class is resets: power-on and manual. The second is general exceptions, which include trap instructions. The third is interrupts. The classes differ in timing. A reset or a general exception takes effect at once and discards the instruction in flight. An interrupt is accepted only at an instruction boundary, and only when the status register does not block it.

When the block accepts an event, it copies the core's current program counter and status word into shadow registers, except for resets. It records the event code in a set of 32-bit event registers and issues a one-cycle redirect. The redirect carries the handler fetch address and the status word the core must adopt. A return command redirects the core back to the shadowed program counter and restores the shadowed status word. Software reads and writes the event registers through a plain register port. Reads are combinational and writes are registered.

Redirects are a single-cycle pulse with no ready signal. The core must accept the redirect in the cycle it is presented, so there is no back-pressure.

Top module: `exc_ctrl`

## Requirements
- R1: While `rst_n` is low (power-on reset), `redirect_vld_o` is 1, `redirect_pc_o` is 0xA0000000 and `new_sr_o` is 0x700000F0. The exception event register reads 0x000. The trap register keeps its previous value.
- R2: A manual reset (`man_rst_i`) wins over every other request in the same cycle. One cycle later the redirect goes to 0xA0000000 with status 0x700000F0, and the exception event register holds 0x020. The interrupt event register keeps its value.
- R3: A general exception is taken whether or not `insn_done_i` is set. One cycle later `spc_o` equals the sampled `cur_pc_i` and `ssr_o` equals the sampled `cur_sr_i`. The redirect goes to `vbr_i`+0x100, and the exception event register holds `gexc_code_i`.
- R4: A trap loads the trap register with `trap_imm_i` shifted left by 2 and zero-extended. It loads the exception event register with 0x160 and redirects to `vbr_i`+0x100. When a general exception arrives in the same cycle, the general exception wins and the trap register is left unchanged.
- R5: An interrupt is taken only when `insn_done_i` is 1 and SR bit 28 (block bit) of `cur_sr_i` is 0. It loads both interrupt event registers with `irq_code_i` and redirects to `vbr_i`+0x600. The exception event register is left unchanged.
- R6: On any non-reset entry, `new_sr_o` equals `cur_sr_i` with bit 30 (privileged) and bit 28 (block) set.
- R7: An interrupt request held while the block bit is set produces no redirect and no register update. It is taken at the first boundary after the bit clears.
- R8: A general exception has priority over an interrupt at the same boundary. In that case the interrupt event register is left unchanged.
- R9: A return command (`rte_i`) redirects to the value `spc_o` held before the edge and sets `new_sr_o` to the value `ssr_o` held before the edge. Any exception or accepted interrupt in the same cycle takes precedence over the return.
- R10: The register port maps the trap register at 0xFFFFFFD0, the exception event register at 0xFFFFFFD4 and the interrupt event register at 0xFFFFFFD8, all read/write. A write is visible on the next cycle. A hardware update in the same cycle beats a software write, and unmapped addresses read 0.
- R11: The second interrupt event register reads at 0x04000000 and is read-only; writes to it change nothing.
- R12: `redirect_vld_o` is a one-cycle pulse. It is 0 in any cycle that does not follow an accepted event, including the cycle after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low, synchronous |
| man_rst_i | input | 1 | Manual reset request |
| gexc_req_i | input | 1 | General exception request |
| gexc_code_i | input | 12 | Event code of the general exception |
| trap_req_i | input | 1 | Trap instruction request |
| trap_imm_i | input | 8 | Trap immediate |
| irq_req_i | input | 1 | Interrupt request (level, held until taken) |
| irq_code_i | input | 12 | Event code of the interrupt |
| insn_done_i | input | 1 | Current instruction completes this cycle |
| rte_i | input | 1 | Return-from-exception command |
| cur_pc_i | input | 32 | Current program counter |
| cur_sr_i | input | 32 | Current status word |
| vbr_i | input | 32 | Vector base address |
| redirect_vld_o | output | 1 | Redirect pulse |
| redirect_pc_o | output | 32 | Fetch address for the redirect |
| new_sr_o | output | 32 | Status word to adopt on redirect |
| spc_o | output | 32 | Shadowed program counter |
| ssr_o | output | 32 | Shadowed status word |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 32 | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |

## Verification
The properties assume that the request inputs, `cur_pc_i`, `cur_sr_i` and `vbr_i` are stable across each sampling edge, and that all requests are low while `rst_n` is low. The `$past` terms then refer to defined values. The stimulus changes inputs only one time unit after a rising edge and holds every request at 0 during reset. A scenario raises more than one request in a cycle only where it tests precedence between them.

// File: rtl/exc_pkg.sv
package exc_pkg;
  typedef enum logic [2:0] {
    EV_NONE = 3'd0,
    EV_MRST = 3'd1,
    EV_GEXC = 3'd2,
    EV_TRAP = 3'd3,
    EV_IRQ  = 3'd4,
    EV_RTE  = 3'd5
  } ev_e;

  localparam int SR_PRIV_BIT  = 30;
  localparam int SR_BLOCK_BIT = 28;
endpackage

// File: rtl/exc_sel.sv
module exc_sel
  import exc_pkg::*;
(
  input  logic man_rst,
  input  logic gexc,
  input  logic trap,
  input  logic irq,
  input  logic boundary,
  input  logic blocked,
  input  logic rte,
  output ev_e  ev
);
  logic irq_ok;
  assign irq_ok = irq && boundary && !blocked;

  always_comb begin
    if (man_rst)     ev = EV_MRST;
    else if (gexc)   ev = EV_GEXC;
    else if (trap)   ev = EV_TRAP;
    else if (irq_ok) ev = EV_IRQ;
    else if (rte)    ev = EV_RTE;
    else             ev = EV_NONE;
  end
endmodule

// File: rtl/exc_ctx.sv
module exc_ctx
  import exc_pkg::*;
#(
  parameter int          XLEN      = 32,
  parameter logic [31:0] RESET_VEC = 32'hA000_0000,
  parameter logic [31:0] SR_RESET  = 32'h7000_00F0,
  parameter logic [31:0] GEXC_OFS  = 32'h0000_0100,
  parameter logic [31:0] IRQ_OFS   = 32'h0000_0600
) (
  input  logic            clk,
  input  logic            rst_n,
  input  ev_e             ev,
  input  logic [XLEN-1:0] cur_pc,
  input  logic [XLEN-1:0] cur_sr,
  input  logic [XLEN-1:0] vbr,
  output logic            redir_vld,
  output logic [XLEN-1:0] redir_pc,
  output logic [XLEN-1:0] redir_sr,
  output logic [XLEN-1:0] spc,
  output logic [XLEN-1:0] ssr
);
  localparam logic [XLEN-1:0] ENTRY_SET =
    (XLEN'(1) << SR_PRIV_BIT) | (XLEN'(1) << SR_BLOCK_BIT);

  logic [XLEN-1:0] entry_sr;
  logic            saves;
  assign entry_sr = cur_sr | ENTRY_SET;
  assign saves    = (ev == EV_GEXC) || (ev == EV_TRAP) || (ev == EV_IRQ);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      redir_vld <= 1'b1;
      redir_pc  <= XLEN'(RESET_VEC);
      redir_sr  <= XLEN'(SR_RESET);
      spc       <= '0;
      ssr       <= '0;
    end else begin
      redir_vld <= (ev != EV_NONE);
      if (saves) begin
        spc <= cur_pc;
        ssr <= cur_sr;
      end
      unique case (ev)
        EV_MRST: begin
          redir_pc <= XLEN'(RESET_VEC);
          redir_sr <= XLEN'(SR_RESET);
        end
        EV_GEXC, EV_TRAP: begin
          redir_pc <= vbr + XLEN'(GEXC_OFS);
          redir_sr <= entry_sr;
        end
        EV_IRQ: begin
          redir_pc <= vbr + XLEN'(IRQ_OFS);
          redir_sr <= entry_sr;
        end
        EV_RTE: begin
          redir_pc <= spc;
          redir_sr <= ssr;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/exc_evregs.sv
module exc_evregs
  import exc_pkg::*;
#(
  parameter int          XLEN      = 32,
  parameter int          CODE_W    = 12,
  parameter int          IMM_W     = 8,
  parameter logic [31:0] TRAP_CODE = 32'h0000_0160,
  parameter logic [31:0] MRST_CODE = 32'h0000_0020,
  parameter logic [31:0] A_TRAP    = 32'hFFFF_FFD0,
  parameter logic [31:0] A_EXC     = 32'hFFFF_FFD4,
  parameter logic [31:0] A_INT     = 32'hFFFF_FFD8,
  parameter logic [31:0] A_INT2    = 32'h0400_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ev_e               ev,
  input  logic [CODE_W-1:0] gexc_code,
  input  logic [IMM_W-1:0]  trap_imm,
  input  logic [CODE_W-1:0] irq_code,
  input  logic              we,
  input  logic [31:0]       addr,
  input  logic [XLEN-1:0]   wdata,
  output logic [XLEN-1:0]   rdata
);
  localparam int IMM_PAD  = XLEN - IMM_W - 2;
  localparam int CODE_PAD = XLEN - CODE_W;

  logic [XLEN-1:0] trap_q, exc_q, int_q, int2_q;
  logic [XLEN-1:0] trap_val, gexc_val, irq_val;

  assign trap_val = {{IMM_PAD{1'b0}}, trap_imm, 2'b00};
  assign gexc_val = {{CODE_PAD{1'b0}}, gexc_code};
  assign irq_val  = {{CODE_PAD{1'b0}}, irq_code};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      exc_q <= '0;
    end else if (ev == EV_MRST) begin
      exc_q <= XLEN'(MRST_CODE);
    end else if (ev == EV_GEXC) begin
      exc_q <= gexc_val;
    end else if (ev == EV_TRAP) begin
      exc_q <= XLEN'(TRAP_CODE);
    end else if (we && addr == A_EXC) begin
      exc_q <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst_n) begin
      if (ev == EV_TRAP)                trap_q <= trap_val;
      else if (we && addr == A_TRAP)    trap_q <= wdata;
      if (ev == EV_IRQ) begin
        int_q  <= irq_val;
        int2_q <= irq_val;
      end else if (we && addr == A_INT) begin
        int_q  <= wdata;
      end
    end
  end

  always_comb begin
    unique case (addr)
      A_TRAP:  rdata = trap_q;
      A_EXC:   rdata = exc_q;
      A_INT:   rdata = int_q;
      A_INT2:  rdata = int2_q;
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/exc_ctrl.sv
module exc_ctrl
  import exc_pkg::*;
#(
  parameter int          XLEN      = 32,
  parameter int          CODE_W    = 12,
  parameter int          IMM_W     = 8,
  parameter logic [31:0] RESET_VEC = 32'hA000_0000,
  parameter logic [31:0] SR_RESET  = 32'h7000_00F0,
  parameter logic [31:0] GEXC_OFS  = 32'h0000_0100,
  parameter logic [31:0] IRQ_OFS   = 32'h0000_0600
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              man_rst_i,
  input  logic              gexc_req_i,
  input  logic [CODE_W-1:0] gexc_code_i,
  input  logic              trap_req_i,
  input  logic [IMM_W-1:0]  trap_imm_i,
  input  logic              irq_req_i,
  input  logic [CODE_W-1:0] irq_code_i,
  input  logic              insn_done_i,
  input  logic              rte_i,
  input  logic [XLEN-1:0]   cur_pc_i,
  input  logic [XLEN-1:0]   cur_sr_i,
  input  logic [XLEN-1:0]   vbr_i,
  output logic              redirect_vld_o,
  output logic [XLEN-1:0]   redirect_pc_o,
  output logic [XLEN-1:0]   new_sr_o,
  output logic [XLEN-1:0]   spc_o,
  output logic [XLEN-1:0]   ssr_o,
  input  logic              reg_we_i,
  input  logic [31:0]       reg_addr_i,
  input  logic [XLEN-1:0]   reg_wdata_i,
  output logic [XLEN-1:0]   reg_rdata_o
);
  ev_e ev;

  exc_sel u_sel (
    .man_rst  (man_rst_i),
    .gexc     (gexc_req_i),
    .trap     (trap_req_i),
    .irq      (irq_req_i),
    .boundary (insn_done_i),
    .blocked  (cur_sr_i[SR_BLOCK_BIT]),
    .rte      (rte_i),
    .ev       (ev)
  );

  exc_ctx #(
    .XLEN(XLEN), .RESET_VEC(RESET_VEC), .SR_RESET(SR_RESET),
    .GEXC_OFS(GEXC_OFS), .IRQ_OFS(IRQ_OFS)
  ) u_ctx (
    .clk       (clk),
    .rst_n     (rst_n),
    .ev        (ev),
    .cur_pc    (cur_pc_i),
    .cur_sr    (cur_sr_i),
    .vbr       (vbr_i),
    .redir_vld (redirect_vld_o),
    .redir_pc  (redirect_pc_o),
    .redir_sr  (new_sr_o),
    .spc       (spc_o),
    .ssr       (ssr_o)
  );

  exc_evregs #(
    .XLEN(XLEN), .CODE_W(CODE_W), .IMM_W(IMM_W)
  ) u_evr (
    .clk       (clk),
    .rst_n     (rst_n),
    .ev        (ev),
    .gexc_code (gexc_code_i),
    .trap_imm  (trap_imm_i),
    .irq_code  (irq_code_i),
    .we        (reg_we_i),
    .addr      (reg_addr_i),
    .wdata     (reg_wdata_i),
    .rdata     (reg_rdata_o)
  );
endmodule

// File: rtl/exc_ctrl_chk.sv
module exc_ctrl_chk
  import exc_pkg::*;
#(
  parameter int          XLEN      = 32,
  parameter logic [31:0] RESET_VEC = 32'hA000_0000,
  parameter logic [31:0] SR_RESET  = 32'h7000_00F0,
  parameter logic [31:0] GEXC_OFS  = 32'h0000_0100,
  parameter logic [31:0] IRQ_OFS   = 32'h0000_0600
) (
  input logic            clk,
  input logic            rst_n,
  input logic            man_rst_i,
  input logic            gexc_req_i,
  input logic            trap_req_i,
  input logic            irq_req_i,
  input logic            insn_done_i,
  input logic            rte_i,
  input logic [XLEN-1:0] cur_pc_i,
  input logic [XLEN-1:0] cur_sr_i,
  input logic [XLEN-1:0] vbr_i,
  input logic            redirect_vld_o,
  input logic [XLEN-1:0] redirect_pc_o,
  input logic [XLEN-1:0] new_sr_o,
  input logic [XLEN-1:0] spc_o,
  input logic [XLEN-1:0] ssr_o
);
  logic irq_take, any_exc;
  assign irq_take = irq_req_i && insn_done_i && !cur_sr_i[SR_BLOCK_BIT];
  assign any_exc  = man_rst_i || gexc_req_i || trap_req_i;

  // R2
  mrst_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    man_rst_i |=> redirect_vld_o && redirect_pc_o == XLEN'(RESET_VEC)
                  && new_sr_o == XLEN'(SR_RESET));

  // R3
  gexc_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gexc_req_i && !man_rst_i) |=> redirect_vld_o
      && redirect_pc_o == $past(vbr_i) + XLEN'(GEXC_OFS)
      && spc_o == $past(cur_pc_i) && ssr_o == $past(cur_sr_i));

  // R6
  entry_sr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!man_rst_i && (gexc_req_i || trap_req_i || irq_take)) |=>
      new_sr_o[SR_PRIV_BIT] && new_sr_o[SR_BLOCK_BIT]);

  // R5
  irq_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_take && !any_exc) |=> redirect_vld_o
      && redirect_pc_o == $past(vbr_i) + XLEN'(IRQ_OFS));

  // R7
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_sr_i[SR_BLOCK_BIT] && !any_exc && !rte_i) |=> !redirect_vld_o);

  // R9
  rte_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rte_i && !any_exc && !irq_take) |=>
      redirect_pc_o == $past(spc_o) && new_sr_o == $past(ssr_o));

  // R12
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!any_exc && !irq_take && !rte_i) |=> !redirect_vld_o);
endmodule

bind exc_ctrl exc_ctrl_chk #(
  .XLEN(XLEN), .RESET_VEC(RESET_VEC), .SR_RESET(SR_RESET),
  .GEXC_OFS(GEXC_OFS), .IRQ_OFS(IRQ_OFS)
) u_chk (.*);

// File: tb/exc_ctrl_bench.sv
module exc_ctrl_bench;
  localparam logic [31:0] A_TRAP = 32'hFFFF_FFD0;
  localparam logic [31:0] A_EXC  = 32'hFFFF_FFD4;
  localparam logic [31:0] A_INT  = 32'hFFFF_FFD8;
  localparam logic [31:0] A_INT2 = 32'h0400_0000;
  localparam logic [31:0] VBR    = 32'h8C00_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        man_rst_i = 0, gexc_req_i = 0, trap_req_i = 0, irq_req_i = 0;
  logic        insn_done_i = 0, rte_i = 0, reg_we_i = 0;
  logic [11:0] gexc_code_i = 0, irq_code_i = 0;
  logic [7:0]  trap_imm_i = 0;
  logic [31:0] cur_pc_i = 0, cur_sr_i = 0, vbr_i = VBR;
  logic [31:0] reg_addr_i = 0, reg_wdata_i = 0;
  logic        redirect_vld_o;
  logic [31:0] redirect_pc_o, new_sr_o, spc_o, ssr_o, reg_rdata_o;

  int total = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  exc_ctrl u_exc_ctrl (.*);

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(logic [31:0] a, output logic [31:0] d);
    reg_addr_i = a; #1; d = reg_rdata_o;
  endtask

  task automatic wr(logic [31:0] a, logic [31:0] d);
    reg_we_i = 1; reg_addr_i = a; reg_wdata_i = d;
    tick();
    reg_we_i = 0;
  endtask

  task automatic clr();
    man_rst_i = 0; gexc_req_i = 0; trap_req_i = 0; irq_req_i = 0;
    insn_done_i = 0; rte_i = 0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rst_n = 0; tick(); tick(); rst_n = 1; tick();
    wr(A_TRAP, 32'h1234);
    rst_n = 0; tick(); tick();
    chk("R1 vld", {31'd0, redirect_vld_o}, 1);
    chk("R1 pc", redirect_pc_o, 32'hA000_0000);
    chk("R1 sr", new_sr_o, 32'h7000_00F0);
    rd(A_EXC, d);  chk("R1 expevt", d, 0);
    rd(A_TRAP, d); chk("R1 trap kept", d, 32'h1234);
    rst_n = 1; tick();
    chk("R12 vld after release", {31'd0, redirect_vld_o}, 0);
  endtask

  task automatic t_mrst();
    logic [31:0] d;
    wr(A_INT, 32'hAAA);
    man_rst_i = 1; gexc_req_i = 1; gexc_code_i = 12'h0E0;
    irq_req_i = 1; insn_done_i = 1; irq_code_i = 12'h3A0;
    tick(); clr();
    chk("R2 vld", {31'd0, redirect_vld_o}, 1);
    chk("R2 pc", redirect_pc_o, 32'hA000_0000);
    chk("R2 sr", new_sr_o, 32'h7000_00F0);
    rd(A_EXC, d); chk("R2 expevt", d, 32'h020);
    rd(A_INT, d); chk("R2 intevt kept", d, 32'hAAA);
    tick();
    chk("R12 pulse", {31'd0, redirect_vld_o}, 0);
  endtask

  task automatic t_gexc();
    logic [31:0] d;
    cur_pc_i = 32'h8000_1000; cur_sr_i = 32'h0000_00F0;
    gexc_req_i = 1; gexc_code_i = 12'h0E0; insn_done_i = 0;
    tick(); clr();
    chk("R3 pc", redirect_pc_o, VBR + 32'h100);
    chk("R3 spc", spc_o, 32'h8000_1000);
    chk("R3 ssr", ssr_o, 32'h0000_00F0);
    chk("R6 sr", new_sr_o, 32'h5000_00F0);
    rd(A_EXC, d); chk("R3 expevt", d, 32'h0E0);
  endtask

  task automatic t_trap();
    logic [31:0] d;
    trap_req_i = 1; trap_imm_i = 8'h3C;
    tick(); clr();
    chk("R4 pc", redirect_pc_o, VBR + 32'h100);
    rd(A_TRAP, d); chk("R4 tra", d, 32'h0F0);
    rd(A_EXC, d);  chk("R4 expevt", d, 32'h160);
    trap_req_i = 1; trap_imm_i = 8'h11; gexc_req_i = 1; gexc_code_i = 12'h1E0;
    tick(); clr();
    rd(A_EXC, d);  chk("R4 gexc wins", d, 32'h1E0);
    rd(A_TRAP, d); chk("R4 tra kept", d, 32'h0F0);
  endtask

  task automatic t_irq();
    logic [31:0] d;
    cur_sr_i = 0;
    irq_req_i = 1; irq_code_i = 12'h3A0; insn_done_i = 0;
    tick();
    chk("R5 wait boundary", {31'd0, redirect_vld_o}, 0);
    insn_done_i = 1;
    tick(); clr();
    chk("R5 vld", {31'd0, redirect_vld_o}, 1);
    chk("R5 pc", redirect_pc_o, VBR + 32'h600);
    rd(A_INT, d);  chk("R5 intevt", d, 32'h3A0);
    rd(A_INT2, d); chk("R5 intevt2", d, 32'h3A0);
    rd(A_EXC, d);  chk("R5 expevt kept", d, 32'h1E0);
  endtask

  task automatic t_irq_blocked();
    logic [31:0] d;
    cur_sr_i = 32'h1000_0000;
    irq_req_i = 1; irq_code_i = 12'h5C0; insn_done_i = 1;
    tick();
    chk("R7 blocked", {31'd0, redirect_vld_o}, 0);
    rd(A_INT, d); chk("R7 intevt kept", d, 32'h3A0);
    cur_sr_i = 0;
    tick(); clr();
    chk("R7 taken pc", redirect_pc_o, VBR + 32'h600);
    rd(A_INT, d); chk("R7 intevt", d, 32'h5C0);
  endtask

  task automatic t_prio();
    logic [31:0] d;
    gexc_req_i = 1; gexc_code_i = 12'h0A0;
    irq_req_i = 1; irq_code_i = 12'h7E0; insn_done_i = 1;
    tick(); clr();
    chk("R8 pc", redirect_pc_o, VBR + 32'h100);
    rd(A_EXC, d); chk("R8 expevt", d, 32'h0A0);
    rd(A_INT, d); chk("R8 intevt kept", d, 32'h5C0);
  endtask

  task automatic t_rte();
    cur_pc_i = 32'h8000_2222; cur_sr_i = 32'h0000_00F3;
    gexc_req_i = 1; gexc_code_i = 12'h0C0;
    tick(); clr();
    cur_pc_i = 32'h8C00_0100; cur_sr_i = 32'h5000_00F3;
    rte_i = 1;
    tick(); clr();
    chk("R9 pc", redirect_pc_o, 32'h8000_2222);
    chk("R9 sr", new_sr_o, 32'h0000_00F3);
    rte_i = 1; gexc_req_i = 1;
    tick(); clr();
    chk("R9 exception beats return", redirect_pc_o, VBR + 32'h100);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    wr(A_EXC, 32'h777);
    wr(A_INT, 32'h888);
    rd(A_EXC, d); chk("R10 expevt rw", d, 32'h777);
    rd(A_INT, d); chk("R10 intevt rw", d, 32'h888);
    trap_req_i = 1; trap_imm_i = 8'h01;
    wr(A_TRAP, 32'h999);
    clr();
    rd(A_TRAP, d); chk("R10 hw beats sw", d, 32'h004);
    rd(32'hFFFF_FFDC, d); chk("R10 unmapped", d, 0);
  endtask

  task automatic t_intevt2();
    logic [31:0] d;
    wr(A_INT2, 32'h123);
    rd(A_INT2, d); chk("R11 read-only", d, 32'h5C0);
    rd(A_INT, d);  chk("R11 intevt untouched", d, 32'h888);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_mrst();
    t_gexc();
    t_trap();
    t_irq();
    t_irq_blocked();
    t_prio();
    t_rte();
    t_regs();
    t_intevt2();
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule